// File: doc/BRIEF.md
# Streaming Argmax Label Unit

This block picks the winning class label at the output of the last layer of a classification network. Class scores arrive four at a time, one group of four signed values per accepted beat. A frame of groups starts with a beat marked as first and ends with a beat marked as last. The block reduces each group to its largest score and that score's lane, and merges the group winner into a running best that persists across the groups of the frame. When the last group has been merged, it presents the winning label and its score.

The work is split over three pipeline stages with one comparator per decision. Stage one compares two pairs of lanes, stage two compares the two pair winners, and stage three compares the group winner with the running best. A class label is the group's position within the frame times four plus the winning lane. Scores offered while the final-layer control pin is low are taken from the stream but discarded, so a shared score stream can pass through without disturbing a frame in progress.

Score input and result output both use valid/ready. The input is accepted on a rising edge when `in_valid` and `in_ready` are both high. A result is taken on a rising edge when `out_valid` and `out_ready` are both high. While a result is held and not taken, `in_ready` is low and the whole pipeline stands still. Nothing in flight is lost, and the held result does not change.

Top module: `argmax_label_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is low and `in_ready` is high. The group counter and the running best hold no earlier frame.
- R2: Lane i of a group is `in_scores[i*W +: W]`, a two's complement signed score. The reported label is the group index times four plus the lane of the frame's largest score. The reported score is that largest value.
- R3: Within one group, when several lanes tie for the largest value, the lowest lane index wins.
- R4: When a later group's winner equals the running best, the running best keeps its earlier, lower label.
- R5: The running best starts from the first group's winner and not from zero or any constant. A frame of all-negative scores reports its true, negative maximum.
- R6: A beat with `in_first` high restarts the group index at 0 and replaces the running best. A single beat with both `in_first` and `in_last` high is a complete one-group frame.
- R7: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. During such a cycle `out_valid`, `out_label` and `out_score` keep their values into the next cycle.
- R8: With `out_ready` held high, `out_valid` is high in the cycle after the third rising edge, counting the edge that accepts the last group. It stays high for one cycle unless another frame completes right behind it. `out_valid` falls only after a result has been taken.
- R9: A beat accepted while `final_layer` is low does not advance the group index, does not change the running best and does not produce a result. `in_ready` does not depend on `final_layer`.
- R10: The first group of a new frame may be accepted on the edge right after the last group of the previous frame. Both frames report correct, independent results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| final_layer | input | 1 | High when the streamed scores belong to the final layer; beats taken while low are discarded |
| in_valid | input | 1 | Score group offered |
| in_ready | output | 1 | Block can take a score group |
| in_first | input | 1 | Offered group is the first of a frame |
| in_last | input | 1 | Offered group is the last of a frame |
| in_scores | input | 4*W | Four signed scores, lane i at bits i*W upward |
| out_valid | output | 1 | Result held for the consumer |
| out_ready | input | 1 | Consumer takes the result |
| out_label | output | LBL_W | Winning class label |
| out_score | output | W | Winning score, signed |

## Verification
Two functions of the block can fall in one cycle. The third stage can merge the last group of one frame while the first group of the next frame restarts the running best. A held result under back-pressure can also coincide with a new frame's groups waiting at the input. The bench drives frames back to back with no idle beat between last and first, and later lowers `out_ready` at random while groups keep arriving. A behavioural argmax model checks every reported label and score against an independently computed maximum. It also checks the `in_ready` rule in every cycle and the exact result cycle while no stall has occurred.

// File: rtl/argmax_pkg.sv
package argmax_pkg;
  localparam int LANES     = 4;
  localparam int LANE_BITS = $clog2(LANES);
  localparam int PAIRS     = LANES / 2;
endpackage

// File: rtl/argmax_cmp.sv
// One signed comparator: b replaces a only when strictly larger, so the
// candidate wired to a (the lower label) keeps ties.
module argmax_cmp #(
  parameter int W  = 8,
  parameter int LW = 2
) (
  input  logic [W-1:0]  a_val,
  input  logic [LW-1:0] a_lbl,
  input  logic [W-1:0]  b_val,
  input  logic [LW-1:0] b_lbl,
  output logic [W-1:0]  w_val,
  output logic [LW-1:0] w_lbl
);
  logic take_b;

  always_comb begin
    take_b = $signed(b_val) > $signed(a_val);
    w_val  = take_b ? b_val : a_val;
    w_lbl  = take_b ? b_lbl : a_lbl;
  end
endmodule

// File: rtl/argmax_pair_stage.sv
// Stage 1: two comparators reduce lanes {0,1} and {2,3} to pair winners.
module argmax_pair_stage
  import argmax_pkg::*;
#(
  parameter int W  = 8,
  parameter int GW = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             adv,
  input  logic                             in_vld,
  input  logic                             in_first,
  input  logic                             in_last,
  input  logic [GW-1:0]                    in_grp,
  input  logic [LANES*W-1:0]               in_scores,
  output logic                             s1_valid,
  output logic                             s1_first,
  output logic                             s1_last,
  output logic [GW-1:0]                    s1_grp,
  output logic [PAIRS-1:0][W-1:0]          s1_val,
  output logic [PAIRS-1:0][LANE_BITS-1:0]  s1_lane
);
  logic [PAIRS-1:0][W-1:0]         win_val;
  logic [PAIRS-1:0][LANE_BITS-1:0] win_lane;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    argmax_cmp #(.W(W), .LW(LANE_BITS)) u_cmp (
      .a_val (in_scores[(2*p)*W +: W]),
      .a_lbl (LANE_BITS'(2*p)),
      .b_val (in_scores[(2*p+1)*W +: W]),
      .b_lbl (LANE_BITS'(2*p+1)),
      .w_val (win_val[p]),
      .w_lbl (win_lane[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_grp   <= '0;
      s1_val   <= '0;
      s1_lane  <= '0;
    end else if (adv) begin
      s1_valid <= in_vld;
      if (in_vld) begin
        s1_first <= in_first;
        s1_last  <= in_last;
        s1_grp   <= in_grp;
        s1_val   <= win_val;
        s1_lane  <= win_lane;
      end
    end
  end
endmodule

// File: rtl/argmax_group_stage.sv
// Stage 2: third comparator picks the group winner and forms its label.
module argmax_group_stage
  import argmax_pkg::*;
#(
  parameter int W     = 8,
  parameter int GW    = 6,
  parameter int LBL_W = GW + LANE_BITS
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             adv,
  input  logic                             s1_valid,
  input  logic                             s1_first,
  input  logic                             s1_last,
  input  logic [GW-1:0]                    s1_grp,
  input  logic [PAIRS-1:0][W-1:0]          s1_val,
  input  logic [PAIRS-1:0][LANE_BITS-1:0]  s1_lane,
  output logic                             s2_valid,
  output logic                             s2_first,
  output logic                             s2_last,
  output logic [W-1:0]                     s2_val,
  output logic [LBL_W-1:0]                 s2_lbl
);
  logic [W-1:0]         g_val;
  logic [LANE_BITS-1:0] g_lane;

  argmax_cmp #(.W(W), .LW(LANE_BITS)) u_cmp (
    .a_val (s1_val[0]),
    .a_lbl (s1_lane[0]),
    .b_val (s1_val[1]),
    .b_lbl (s1_lane[1]),
    .w_val (g_val),
    .w_lbl (g_lane)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_first <= 1'b0;
      s2_last  <= 1'b0;
      s2_val   <= '0;
      s2_lbl   <= '0;
    end else if (adv) begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_first <= s1_first;
        s2_last  <= s1_last;
        s2_val   <= g_val;
        s2_lbl   <= {s1_grp, g_lane};
      end
    end
  end
endmodule

// File: rtl/argmax_running_stage.sv
// Stage 3: fourth comparator merges the group winner into the running best
// and loads the held result at the end of a frame.
module argmax_running_stage #(
  parameter int W     = 8,
  parameter int LBL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             s2_valid,
  input  logic             s2_first,
  input  logic             s2_last,
  input  logic [W-1:0]     s2_val,
  input  logic [LBL_W-1:0] s2_lbl,
  output logic             out_valid,
  output logic [LBL_W-1:0] out_label,
  output logic [W-1:0]     out_score
);
  logic [W-1:0]     best_val;
  logic [LBL_W-1:0] best_lbl;
  logic [W-1:0]     cmp_val;
  logic [LBL_W-1:0] cmp_lbl;
  logic [W-1:0]     nxt_val;
  logic [LBL_W-1:0] nxt_lbl;

  argmax_cmp #(.W(W), .LW(LBL_W)) u_cmp (
    .a_val (best_val),
    .a_lbl (best_lbl),
    .b_val (s2_val),
    .b_lbl (s2_lbl),
    .w_val (cmp_val),
    .w_lbl (cmp_lbl)
  );

  always_comb begin
    nxt_val = s2_first ? s2_val : cmp_val;
    nxt_lbl = s2_first ? s2_lbl : cmp_lbl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_val  <= '0;
      best_lbl  <= '0;
      out_valid <= 1'b0;
      out_label <= '0;
      out_score <= '0;
    end else if (adv) begin
      if (s2_valid) begin
        best_val <= nxt_val;
        best_lbl <= nxt_lbl;
      end
      out_valid <= s2_valid && s2_last;
      if (s2_valid && s2_last) begin
        out_label <= nxt_lbl;
        out_score <= nxt_val;
      end
    end
  end
endmodule

// File: rtl/argmax_label_unit.sv
module argmax_label_unit
  import argmax_pkg::*;
#(
  parameter int W     = 8,
  parameter int LBL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               final_layer,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_first,
  input  logic               in_last,
  input  logic [LANES*W-1:0] in_scores,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [LBL_W-1:0]   out_label,
  output logic [W-1:0]       out_score
);
  localparam int GW = LBL_W - LANE_BITS;

  logic                            adv;
  logic                            take;
  logic [GW-1:0]                   grp_cnt;
  logic [GW-1:0]                   cur_grp;
  logic                            s1_valid, s1_first, s1_last;
  logic [GW-1:0]                   s1_grp;
  logic [PAIRS-1:0][W-1:0]         s1_val;
  logic [PAIRS-1:0][LANE_BITS-1:0] s1_lane;
  logic                            s2_valid, s2_first, s2_last;
  logic [W-1:0]                    s2_val;
  logic [LBL_W-1:0]                s2_lbl;

  // Whole pipeline moves together; it freezes only while a result waits.
  always_comb begin
    adv      = !out_valid || out_ready;
    in_ready = adv;
    take     = in_valid && adv && final_layer;
    cur_grp  = in_first ? '0 : grp_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_cnt <= '0;
    else if (take) grp_cnt <= cur_grp + GW'(1);
  end

  argmax_pair_stage #(.W(W), .GW(GW)) u_pair (
    .clk, .rst_n, .adv,
    .in_vld    (take),
    .in_first, .in_last,
    .in_grp    (cur_grp),
    .in_scores,
    .s1_valid, .s1_first, .s1_last, .s1_grp, .s1_val, .s1_lane
  );

  argmax_group_stage #(.W(W), .GW(GW), .LBL_W(LBL_W)) u_group (
    .clk, .rst_n, .adv,
    .s1_valid, .s1_first, .s1_last, .s1_grp, .s1_val, .s1_lane,
    .s2_valid, .s2_first, .s2_last, .s2_val, .s2_lbl
  );

  argmax_running_stage #(.W(W), .LBL_W(LBL_W)) u_run (
    .clk, .rst_n, .adv,
    .s2_valid, .s2_first, .s2_last, .s2_val, .s2_lbl,
    .out_valid, .out_label, .out_score
  );
endmodule

// File: rtl/argmax_label_unit_sva.sv
module argmax_label_unit_sva
  import argmax_pkg::*;
#(
  parameter int W     = 8,
  parameter int LBL_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               final_layer,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_first,
  input logic               in_last,
  input logic [LANES*W-1:0] in_scores,
  input logic               out_valid,
  input logic               out_ready,
  input logic [LBL_W-1:0]   out_label,
  input logic [W-1:0]       out_score
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));

  assert_stall_blocks_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_label) && $stable(out_score)));

  assert_drop_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  assert_rise_needs_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_ready));
endmodule

bind argmax_label_unit argmax_label_unit_sva #(.W(W), .LBL_W(LBL_W)) u_sva (.*);

// File: tb/argmax_label_unit_tb.sv
module argmax_label_unit_tb;
  localparam int W     = 8;
  localparam int LBL_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic final_layer = 1'b0;
  logic in_valid = 1'b0;
  logic in_first = 1'b0;
  logic in_last = 1'b0;
  logic [4*W-1:0] in_scores = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [LBL_W-1:0] out_label;
  logic [W-1:0] out_score;

  always #10 clk = ~clk;

  argmax_label_unit #(.W(W), .LBL_W(LBL_W)) u_dut (
    .clk, .rst_n, .final_layer, .in_valid, .in_ready, .in_first, .in_last,
    .in_scores, .out_valid, .out_ready, .out_label, .out_score
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int q_lbl[$], q_val[$], q_due[$];
  int m_best_val = 0, m_best_lbl = 0, m_grp = 0;
  bit timing_chk = 1'b1;
  string cur_tag = "R2";

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // One clock: judge outputs, apply new inputs, update the model.
  task automatic drive(bit v, bit f, bit l, bit fl, int s0, int s1, int s2, int s3, bit rdy);
    int s[4];
    int bl, lbl;
    s = '{s0, s1, s2, s3};
    @(negedge clk);
    if (timing_chk)
      check(cur_tag, int'(out_valid), int'(q_lbl.size() > 0 && q_due[0] <= cyc), "result cycle (R8)");
    if (out_valid) begin
      if (q_lbl.size() == 0) check(cur_tag, 1, 0, "result with no frame completed");
      else begin
        check(cur_tag, int'(out_label), q_lbl[0], "label");
        check(cur_tag, int'($signed(out_score)), q_val[0], "score");
      end
    end
    in_valid = v; in_first = f; in_last = l; final_layer = fl; out_ready = rdy;
    for (int i = 0; i < 4; i++) in_scores[i*W +: W] = W'(s[i]);
    #1;
    check("R7", int'(in_ready), int'(!(out_valid && !rdy)), "in_ready");
    if (out_valid && rdy && q_lbl.size() > 0) begin
      void'(q_lbl.pop_front()); void'(q_val.pop_front()); void'(q_due.pop_front());
    end
    if (v && in_ready && fl) begin
      if (f) m_grp = 0;
      bl = 0;
      for (int i = 1; i < 4; i++) if (s[i] > s[bl]) bl = i;
      lbl = m_grp * 4 + bl;
      if (f || s[bl] > m_best_val) begin
        m_best_val = s[bl];
        m_best_lbl = lbl;
      end
      m_grp++;
      if (l) begin
        q_lbl.push_back(m_best_lbl); q_val.push_back(m_best_val); q_due.push_back(cyc + 3);
      end
    end
  endtask

  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 1, 0, 0, 0, 0, rdy);
  endtask

  function automatic int rnd_score(bit narrow);
    return narrow ? $urandom_range(0, 6) - 3 : $urandom_range(0, 255) - 128;
  endfunction

  task automatic rnd_frame(bit rdy_rand);
    int ng;
    bit narrow;
    ng = $urandom_range(1, 12);
    narrow = $urandom_range(0, 1);
    for (int g = 0; g < ng; g++) begin
      if ($urandom_range(0, 4) == 0)
        drive(1, 0, 0, 0, 127, 127, 127, 127, rdy_rand ? bit'($urandom_range(0, 1)) : 1'b1);
      drive(1, g == 0, g == ng - 1, 1, rnd_score(narrow), rnd_score(narrow),
            rnd_score(narrow), rnd_score(narrow), rdy_rand ? bit'($urandom_range(0, 1)) : 1'b1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0, "out_valid in reset");
    check("R1", int'(in_ready), 1, "in_ready in reset");
    rst_n = 1'b1;
    cur_tag = "R1";
    idle(3, 1);

    cur_tag = "R3";
    drive(1, 1, 1, 1, 3, -5, 7, 7, 1);
    idle(4, 1);
    drive(1, 1, 1, 1, -2, -2, -2, -2, 1);
    idle(4, 1);

    cur_tag = "R4";
    drive(1, 1, 0, 1, 5, 1, 1, 1, 1);
    drive(1, 0, 1, 1, 5, 5, 2, 0, 1);
    idle(4, 1);

    cur_tag = "R5";
    drive(1, 1, 0, 1, -9, -3, -7, -100, 1);
    drive(1, 0, 0, 1, -50, -4, -60, -8, 1);
    drive(1, 0, 1, 1, -128, -20, -3, -90, 1);
    idle(4, 1);

    cur_tag = "R9";
    drive(1, 1, 0, 1, 1, 2, 3, 4, 1);
    drive(1, 0, 0, 0, 100, 100, 100, 100, 1);
    drive(1, 0, 1, 1, 0, 9, 0, 0, 1);
    drive(1, 1, 1, 0, 50, 50, 50, 50, 1);
    idle(5, 1);

    cur_tag = "R6";
    drive(1, 1, 0, 1, 10, 20, 30, 40, 1);
    drive(1, 1, 1, 1, -1, 6, -1, -1, 1);
    idle(4, 1);

    cur_tag = "R10";
    for (int k = 0; k < 60; k++) rnd_frame(1'b0);
    idle(4, 1);

    cur_tag = "R7";
    timing_chk = 1'b0;
    for (int k = 0; k < 60; k++) begin
      rnd_frame(1'b1);
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3), bit'($urandom_range(0, 1)));
    end
    idle(8, 1);
    check("R8", q_lbl.size(), 0, "results left undelivered");
    summary();
    $finish;
  end
endmodule